// File: doc/BRIEF.md
# Bypass Linear Local Network

This block moves flits between neighbouring processing elements over a bidirectional chain of small switches, one switch per element. Every switch holds one bypass bit for eastward traffic (towards higher indices) and one for westward traffic. A flit that reaches a switch either leaves through that element's delivery port when its destination matches, or passes straight on when the bypass bit is set, or is written into the switch's FIFO for that direction and carries on in a later cycle. One switch setting therefore cuts the chain into circuit segments, and each segment is crossed within one cycle. Several segments that do not overlap carry traffic in the same cycle.

Each launched flit carries a one-hot hop vector that moves down one position at every switch it reaches. When the vector empties, the flit is held in a register at that switch. This bounds the combinational path to `MAXHOP` switches.

In dynamic mode the stored bits are not used and every switch passes traffic through. A round-robin arbiter then gives the whole chain to one source per cycle, in the manner of a bus.

Top module: `lbnet`

## Requirements
- R1: After reset no delivery is valid, no injection is accepted while none is offered, and every switch is set to stop in both directions (all bits 0), with empty FIFOs.
- R2: `cfg_bits[2*j]` is the eastward bypass bit of switch j and `cfg_bits[2*j+1]` the westward one; 1 means pass through, 0 means stop. A flit with a destination index above its source travels east, and one with a destination below its source travels west.
- R3: A flit whose path crosses only bypassing switches, up to its destination, is delivered in the same cycle in which it is injected.
- R4: A flit that stops at a switch other than its destination is held in that switch's FIFO for its direction and leaves from there in a later cycle. FIFOs keep order.
- R5: A flit crosses at most `MAXHOP` links per cycle. If the destination lies exactly `MAXHOP` links away, the flit is delivered. Otherwise it is held at the switch `MAXHOP` links on.
- R6: Transfers on segments that do not overlap complete in the same cycle, for example 0 to 2 and 2 to 4 with switches 1 and 3 set to bypass eastward.
- R7: At a switch, a passing flit has priority over a local launch in that direction. Among local sources the FIFO head comes before the element's injection. `inj_ready` is high only for an injection that is taken in this cycle.
- R8: When `dyn_mode` is 1, the stored bits are ignored and every switch bypasses. At most one source launches per cycle. It is chosen round-robin over source slots s = 2*j + d (d = 0 east, d = 1 west), starting at slot 0 after reset and moving to the slot after the winner.
- R9: A configuration load is accepted only in a cycle in which all FIFOs are empty. Otherwise it is dropped and the old setting stays in force.
- R10: A source launches only when the flit will be delivered, or when the FIFO where the flit will stop has room. No FIFO overflows.
- R11: Westward traffic follows the same rules as eastward traffic, using the westward bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dyn_mode | input | 1 | 1 selects arbitrated bus operation |
| cfg_load | input | 1 | Request to load the switch setting |
| cfg_bits | input | 2*N | Bypass bits, two per switch |
| inj_valid | input | N | Injection offered, one bit per element |
| inj_dst | input | N*AW | Destination index per element |
| inj_data | input | N*W | Payload per element |
| inj_ready | output | N | Injection taken this cycle |
| ej_e_valid | output | N | Eastward flit delivered to element |
| ej_e_data | output | N*W | Eastward delivered payload |
| ej_w_valid | output | N | Westward flit delivered to element |
| ej_w_data | output | N*W | Westward delivered payload |

## Verification
At one switch, a flit passing through and the element's own launch can both want the outgoing link in the same cycle. The bench sets every switch to bypass and injects at elements 0 and 1 towards element 3 in one cycle. It then requires that only element 0 is taken and that element 0's payload arrives, and in the next cycle that element 1's payload arrives. In the same way, a FIFO that is drained and refilled in one cycle is exercised by two injections in a row under an all-stop setting, and the bench checks that both payloads arrive in order.

// File: rtl/lbnet.sv
module lbnet #(
  parameter int N      = 8,
  parameter int W      = 8,
  parameter int MAXHOP = 4,
  parameter int DEPTH  = 2,
  localparam int AW    = $clog2(N)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dyn_mode,
  input  logic            cfg_load,
  input  logic [2*N-1:0]  cfg_bits,
  input  logic [N-1:0]    inj_valid,
  input  logic [N*AW-1:0] inj_dst,
  input  logic [N*W-1:0]  inj_data,
  output logic [N-1:0]    inj_ready,
  output logic [N-1:0]    ej_e_valid,
  output logic [N*W-1:0]  ej_e_data,
  output logic [N-1:0]    ej_w_valid,
  output logic [N*W-1:0]  ej_w_data
);
  localparam int FW = AW + W;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int S  = 2 * N;
  localparam int SW = $clog2(S);

  logic [2*N-1:0] cfg_q;
  logic [FW-1:0]  mem [2][N][DEPTH];
  logic [PW-1:0]  rp [2][N], wp [2][N];
  logic [CW-1:0]  cnt [2][N];
  logic [SW-1:0]  ptr;

  logic           byp [2][N], cv [2][N], cff [2][N], cok [2][N];
  logic [FW-1:0]  cf [2][N], fin [2][N];
  logic           fwr [2][N], frd [2][N], ejv [2][N], acc [2][N], lv [2][N];
  logic [W-1:0]   ejd [2][N];
  logic [MAXHOP-1:0] lh [2][N];
  logic [S-1:0]   req, lsrc;
  logic           found, all_empty;
  logic [SW-1:0]  gsel;

  always_comb begin
    all_empty = 1'b1;
    for (int d = 0; d < 2; d++)
      for (int j = 0; j < N; j++)
        if (cnt[d][j] != '0) all_empty = 1'b0;
  end

  always_comb begin
    int p;
    logic done;
    for (int d = 0; d < 2; d++)
      for (int j = 0; j < N; j++) byp[d][j] = dyn_mode | cfg_q[2*j+d];
    for (int d = 0; d < 2; d++)
      for (int j = 0; j < N; j++) begin
        cff[d][j] = (cnt[d][j] != '0);
        cf[d][j]  = mem[d][j][rp[d][j]];
        cv[d][j]  = cff[d][j];
        if (!cff[d][j]) begin
          cf[d][j] = {inj_dst[j*AW +: AW], inj_data[j*W +: W]};
          cv[d][j] = inj_valid[j] && ((d == 0) ? (inj_dst[j*AW +: AW] > AW'(j))
                                               : (inj_dst[j*AW +: AW] < AW'(j)));
        end
        cok[d][j] = 1'b0;
        done = 1'b0;
        for (int k = 1; k <= MAXHOP; k++) begin
          p = (d == 0) ? j + k : j - k;
          if (!done && p >= 0 && p < N) begin
            if (cf[d][j][FW-1 -: AW] == AW'(p)) begin
              cok[d][j] = 1'b1;
              done = 1'b1;
            end else if (!byp[d][p] || k == MAXHOP || p == ((d == 0) ? N-1 : 0)) begin
              cok[d][j] = (cnt[d][p] < CW'(DEPTH));
              done = 1'b1;
            end
          end
        end
        req[2*j+d] = cv[d][j] && cok[d][j];
      end
  end

  always_comb begin
    int s, j;
    logic cur_v, nv, thru;
    logic [FW-1:0] cur_f, nf;
    logic [MAXHOP-1:0] cur_h, nh, hh;
    found = 1'b0;
    gsel  = '0;
    for (int i = 0; i < S; i++) begin
      s = (int'(ptr) + i) % S;
      if (!found && req[s]) begin
        found = 1'b1;
        gsel  = SW'(s);
      end
    end
    for (int d = 0; d < 2; d++) begin
      cur_v = 1'b0; cur_f = '0; cur_h = '0;
      for (int i = 0; i < N; i++) begin
        j = (d == 0) ? i : N - 1 - i;
        ejv[d][j] = 1'b0; ejd[d][j] = '0; fwr[d][j] = 1'b0; fin[d][j] = '0;
        frd[d][j] = 1'b0; acc[d][j] = 1'b0; thru = 1'b0;
        hh = cur_h >> 1;
        nv = 1'b0; nf = '0; nh = '0;
        if (cur_v) begin
          if (cur_f[FW-1 -: AW] == AW'(j)) begin
            ejv[d][j] = 1'b1;
            ejd[d][j] = cur_f[W-1:0];
          end else if (!byp[d][j] || hh == '0 || j == ((d == 0) ? N-1 : 0)) begin
            fwr[d][j] = 1'b1;
            fin[d][j] = cur_f;
          end else thru = 1'b1;
        end
        if (thru) begin
          nv = 1'b1; nf = cur_f; nh = hh;
        end else if (req[2*j+d] && (!dyn_mode || (found && gsel == SW'(2*j+d)))) begin
          nv = 1'b1; nf = cf[d][j]; nh[MAXHOP-1] = 1'b1;
          frd[d][j] = cff[d][j];
          acc[d][j] = !cff[d][j];
        end
        lv[d][j] = nv; lh[d][j] = nh;
        lsrc[2*j+d] = frd[d][j] | acc[d][j];
        cur_v = nv; cur_f = nf; cur_h = nh;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign inj_ready[g]        = acc[0][g] | acc[1][g];
    assign ej_e_valid[g]       = ejv[0][g];
    assign ej_e_data[g*W +: W] = ejd[0][g];
    assign ej_w_valid[g]       = ejv[1][g];
    assign ej_w_data[g*W +: W] = ejd[1][g];
  end

  always_ff @(posedge clk)
    for (int d = 0; d < 2; d++)
      for (int j = 0; j < N; j++)
        if (fwr[d][j]) mem[d][j][wp[d][j]] <= fin[d][j];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ptr   <= '0;
      for (int d = 0; d < 2; d++)
        for (int j = 0; j < N; j++) begin
          rp[d][j] <= '0; wp[d][j] <= '0; cnt[d][j] <= '0;
        end
    end else begin
      if (cfg_load && all_empty) cfg_q <= cfg_bits;
      if (dyn_mode && found) ptr <= (gsel == SW'(S-1)) ? '0 : gsel + 1'b1;
      for (int d = 0; d < 2; d++)
        for (int j = 0; j < N; j++) begin
          if (fwr[d][j]) wp[d][j] <= (wp[d][j] == PW'(DEPTH-1)) ? '0 : wp[d][j] + 1'b1;
          if (frd[d][j]) rp[d][j] <= (rp[d][j] == PW'(DEPTH-1)) ? '0 : rp[d][j] + 1'b1;
          cnt[d][j] <= cnt[d][j] + CW'(fwr[d][j]) - CW'(frd[d][j]);
        end
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_chk_d
    for (genvar j = 0; j < N; j++) begin : g_chk_j
      assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fwr[d][j] |-> (cnt[d][j] != CW'(DEPTH)));
      assert_hop_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lv[d][j] |-> $onehot(lh[d][j]));
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_chk_rdy
    assert_ready_needs_offer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inj_ready[j] |-> inj_valid[j]);
  end

  assert_single_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dyn_mode |-> $onehot0(lsrc));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !all_empty) |=> $stable(cfg_q));

endmodule

// File: tb/lbnet_tb.sv
module lbnet_tb;
  localparam int N = 8, W = 8, AW = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            dyn_mode, cfg_load;
  logic [2*N-1:0]  cfg_bits;
  logic [N-1:0]    inj_valid;
  logic [N*AW-1:0] inj_dst;
  logic [N*W-1:0]  inj_data;
  logic [N-1:0]    inj_ready, ej_e_valid, ej_w_valid;
  logic [N*W-1:0]  ej_e_data, ej_w_data;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lbnet #(.N(N), .W(W), .MAXHOP(4), .DEPTH(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .dyn_mode(dyn_mode), .cfg_load(cfg_load),
    .cfg_bits(cfg_bits), .inj_valid(inj_valid), .inj_dst(inj_dst),
    .inj_data(inj_data), .inj_ready(inj_ready), .ej_e_valid(ej_e_valid),
    .ej_e_data(ej_e_data), .ej_w_valid(ej_w_valid), .ej_w_data(ej_w_data));

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic put(input int j, input int dst, input logic [7:0] dat);
    inj_valid[j] = 1'b1;
    inj_dst[j*AW +: AW] = AW'(dst);
    inj_data[j*W +: W] = dat;
  endtask

  task automatic clr();
    inj_valid = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [2*N-1:0] v);
    @(negedge clk);
    cfg_load = 1'b1; cfg_bits = v;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 no east delivery", 32'(ej_e_valid), 0);
    check("R1 no west delivery", 32'(ej_w_valid), 0);
    check("R1 no ready", 32'(inj_ready), 0);
    put(0, 2, 8'h11);
    #2;
    check("R1 all-stop after reset: no same-cycle delivery", 32'(ej_e_valid), 0);
    check("R1 inject taken", 32'(inj_ready), 32'h01);
    @(negedge clk); clr(); #2;
    check("R1 R4 delivered from FIFO next cycle", 32'(ej_e_valid), 32'h04);
    check("R4 payload", 32'(ej_e_data[2*W +: W]), 32'h11);
    idle(3);
  endtask

  task automatic t_multihop();
    load(16'h0014);
    put(0, 3, 8'hA1); #2;
    check("R3 R2 same-cycle delivery at 3", 32'(ej_e_valid), 32'h08);
    check("R3 payload", 32'(ej_e_data[3*W +: W]), 32'hA1);
    @(negedge clk); clr(); idle(3);
  endtask

  task automatic t_disjoint();
    load(16'h0044);
    put(0, 2, 8'hB0); put(2, 4, 8'hB2); #2;
    check("R6 both segments deliver", 32'(ej_e_valid), 32'h14);
    check("R6 both taken", 32'(inj_ready), 32'h05);
    check("R6 payload at 2", 32'(ej_e_data[2*W +: W]), 32'hB0);
    check("R6 payload at 4", 32'(ej_e_data[4*W +: W]), 32'hB2);
    @(negedge clk); clr(); idle(3);
  endtask

  task automatic t_stop();
    load(16'h0000);
    put(0, 3, 8'hC1); #2;
    check("R4 stop: no delivery", 32'(ej_e_valid), 0);
    @(negedge clk); put(0, 3, 8'hC2); #2;
    check("R10 second flit accepted into refilled FIFO", 32'(inj_ready), 32'h01);
    check("R4 still in flight", 32'(ej_e_valid), 0);
    @(negedge clk); clr(); #2;
    check("R4 first arrives", 32'(ej_e_valid), 32'h08);
    check("R4 first payload in order", 32'(ej_e_data[3*W +: W]), 32'hC1);
    @(negedge clk); #2;
    check("R10 second payload in order", 32'(ej_e_data[3*W +: W]), 32'hC2);
    idle(3);
  endtask

  task automatic t_hop();
    load(16'h5555);
    put(0, 4, 8'hD4); #2;
    check("R5 delivered at exactly MAXHOP", 32'(ej_e_valid), 32'h10);
    check("R5 payload", 32'(ej_e_data[4*W +: W]), 32'hD4);
    @(negedge clk); put(0, 5, 8'hD5); #2;
    check("R5 beyond limit: no same-cycle delivery", 32'(ej_e_valid), 0);
    @(negedge clk); clr(); #2;
    check("R5 delivered after latch", 32'(ej_e_valid), 32'h20);
    check("R5 latched payload", 32'(ej_e_data[5*W +: W]), 32'hD5);
    idle(3);
  endtask

  task automatic t_west();
    load(16'h2000);
    put(7, 5, 8'hE5); #2;
    check("R11 westward same-cycle delivery", 32'(ej_w_valid), 32'h20);
    check("R11 no eastward delivery", 32'(ej_e_valid), 0);
    check("R11 payload", 32'(ej_w_data[5*W +: W]), 32'hE5);
    @(negedge clk); clr(); idle(3);
  endtask

  task automatic t_priority();
    load(16'h5555);
    put(0, 3, 8'hF0); put(1, 3, 8'hF1); #2;
    check("R7 passing flit wins at switch 1", 32'(inj_ready), 32'h01);
    check("R7 element 0 payload", 32'(ej_e_data[3*W +: W]), 32'hF0);
    @(negedge clk); inj_valid[0] = 1'b0; #2;
    check("R7 element 1 goes next", 32'(inj_ready), 32'h02);
    check("R7 element 1 payload", 32'(ej_e_data[3*W +: W]), 32'hF1);
    @(negedge clk); clr(); idle(3);
  endtask

  task automatic t_dyn();
    load(16'h0000);
    dyn_mode = 1'b1;
    put(0, 3, 8'h60); put(5, 2, 8'h65); #2;
    check("R8 slot 0 wins first", 32'(inj_ready), 32'h01);
    check("R8 stored stop bits ignored", 32'(ej_e_valid), 32'h08);
    check("R8 one launch only", 32'(ej_w_valid), 0);
    @(negedge clk); put(0, 3, 8'h61); #2;
    check("R8 round-robin to slot 11", 32'(inj_ready), 32'h20);
    check("R8 westward delivery", 32'(ej_w_valid), 32'h04);
    check("R8 westward payload", 32'(ej_w_data[2*W +: W]), 32'h65);
    @(negedge clk); inj_valid[5] = 1'b0; #2;
    check("R8 wrap back to slot 0", 32'(inj_ready), 32'h01);
    check("R8 payload", 32'(ej_e_data[3*W +: W]), 32'h61);
    @(negedge clk); clr(); dyn_mode = 1'b0; idle(3);
  endtask

  task automatic t_cfg_lock();
    load(16'h0000);
    put(0, 3, 8'h90);
    @(negedge clk); clr(); cfg_load = 1'b1; cfg_bits = 16'h5555;
    @(negedge clk); cfg_load = 1'b0; #2;
    check("R9 flit drains under stop setting", 32'(ej_e_valid), 32'h08);
    idle(2);
    put(0, 3, 8'h91); #2;
    check("R9 load while busy dropped", 32'(ej_e_valid), 0);
    @(negedge clk); clr(); idle(4);
    load(16'h5555);
    put(0, 3, 8'h92); #2;
    check("R9 load while empty accepted", 32'(ej_e_valid), 32'h08);
    @(negedge clk); clr(); idle(3);
  endtask

  initial begin
    rst_n = 1'b0; dyn_mode = 1'b0; cfg_load = 1'b0; cfg_bits = '0;
    inj_valid = '0; inj_dst = '0; inj_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    t_reset();
    t_multihop();
    t_disjoint();
    t_stop();
    t_hop();
    t_west();
    t_priority();
    t_dyn();
    t_cfg_lock();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule